// File: doc/BRIEF.md
# Self-Routing Omega Switch Fabric

This block connects N input ports to N output ports through log2(N) stages of 2x2 switching elements, with a perfect-shuffle wiring ahead of every stage. Each input port offers a valid flag, a destination index and a data word. Each element sets itself from one destination bit per stage, most significant bit first. At stage k the bit used is bit (log2(N)-1-k), where 0 selects the upper output and 1 the lower. From any input to any output there is exactly one path. Requests whose paths do not collide all reach their outputs together, one clock after they are presented.

The fabric is blocking. When two requests need the same element output at any stage, the request from the lower-numbered input port keeps the link. The other request is dropped and its port's blocked flag is raised. A dropped request never reaches its destination, even when that output port is free. A request can also ask for broadcast. The elements then use their upper-broadcast or lower-broadcast settings so that the word reaches every output port. A broadcast is only admitted when no other valid request exists in that cycle.

Top module: `omega_fabric`

## Requirements
- R1: While reset is high, every out_valid and blocked bit is 0, and out_data and out_src read 0, after the next clock edge.
- R2: The outputs are registered. Requests presented before a clock edge appear after that edge and stay for exactly one cycle. A cycle with no valid input yields all outputs invalid and no blocked flag.
- R3: A delivered request appears on the output port whose index equals its destination, with its data word and its input port index on out_src. An output port that receives nothing shows out_valid 0, out_data 0 and out_src 0.
- R4: The reversal pattern (input i to output N-1-i for every i) is delivered completely, with no blocked flag.
- R5: Blocking is detected at internal links. With input 0 sent to output 5 and input 6 sent to output 4, input 6 is blocked and output 4 stays invalid, even though no other request targets output 4.
- R6: When requests contend for a link, the one from the lower-numbered input port wins. The loser's blocked flag is raised in the same output cycle in which the winners appear. Example: every port sending to output 3 delivers input 0's word and blocks ports 1 to 7.
- R7: A blocked flag is raised only for a port that presented a valid request. Every valid non-broadcast request is either delivered or blocked, never both.
- R8: A broadcast request (in_bcast set) that is the only valid request in its cycle appears on all N output ports with its data and its input index. Its destination bits are ignored.
- R9: A broadcast request presented together with any other valid request is blocked. The remaining non-broadcast requests are routed exactly as if the broadcast were absent. Two broadcasts in one cycle are both blocked.
- R10: The identity pattern (input i to output i) is delivered completely, with no blocked flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Request present, one bit per input port |
| in_bcast | input | N | Request is a broadcast, one bit per input port |
| in_dest | input | N x log2(N) | Destination output index per input port |
| in_data | input | N x W | Data word per input port |
| out_valid | output | N | Word delivered, one bit per output port |
| out_data | output | N x W | Delivered word per output port, 0 when invalid |
| out_src | output | N x log2(N) | Input index of the delivered word, 0 when invalid |
| blocked | output | N | Request from this input port was dropped in the fabric |

## Verification
The bound assertions check properties that hold in every cycle:
- reset clears the outputs;
- an idle cycle produces nothing;
- delivered and blocked counts add up to the number of non-broadcast requests;
- input port 0 is never blocked;
- a lone broadcast lights every output.

Which request wins a given internal collision, the exact output port and word for each request, and the handling of broadcasts mixed with other traffic depend on the whole input pattern. Only the bench's reference model, compared on every clock over the directed patterns and a long random run, can show those.

// File: rtl/omega_pkg.sv
package omega_pkg;
  typedef enum logic [1:0] {
    SW_STRAIGHT = 2'd0,
    SW_CROSS    = 2'd1,
    SW_UP_BCAST = 2'd2,
    SW_LO_BCAST = 2'd3
  } sw_mode_e;

  // inverse of the perfect shuffle: line q of a stage is fed by line rotr(q)
  function automatic int unsigned shuffle_from(int unsigned q, int unsigned bits);
    return (q >> 1) | ((q & 1) << (bits - 1));
  endfunction
endpackage

// File: rtl/omega_admit.sv
module omega_admit #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_vld,
  input  logic [N-1:0] req_bc,
  output logic [N-1:0] adm_vld,
  output logic [N-1:0] adm_bc,
  output logic [N-1:0] rej
);
  logic solo;

  // a broadcast claims every link, so it may enter only when alone
  assign solo    = ($countones(req_vld) == 1);
  assign rej     = req_vld & req_bc & {N{~solo}};
  assign adm_vld = req_vld & ~rej;
  assign adm_bc  = req_vld & req_bc & {N{solo}};
endmodule

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int LOGN = 3,
  parameter int W    = 16,
  parameter int BIT  = 2
) (
  input  logic            a_vld,
  input  logic            a_bc,
  input  logic [LOGN-1:0] a_dst,
  input  logic [LOGN-1:0] a_src,
  input  logic [W-1:0]    a_dat,
  input  logic            b_vld,
  input  logic            b_bc,
  input  logic [LOGN-1:0] b_dst,
  input  logic [LOGN-1:0] b_src,
  input  logic [W-1:0]    b_dat,
  output logic            u_vld,
  output logic            u_bc,
  output logic [LOGN-1:0] u_dst,
  output logic [LOGN-1:0] u_src,
  output logic [W-1:0]    u_dat,
  output logic            l_vld,
  output logic            l_bc,
  output logic [LOGN-1:0] l_dst,
  output logic [LOGN-1:0] l_src,
  output logic [W-1:0]    l_dat,
  output logic            a_lost,
  output logic            b_lost
);
  sw_mode_e mode;
  logic     pass_a, pass_b;

  always_comb begin
    a_lost = 1'b0;
    b_lost = 1'b0;
    pass_a = a_vld;
    pass_b = b_vld;
    mode   = SW_STRAIGHT;
    if (a_vld && a_bc) begin
      mode   = SW_UP_BCAST;
      b_lost = b_vld;
      pass_b = 1'b0;
    end else if (b_vld && b_bc) begin
      mode   = SW_LO_BCAST;
      a_lost = a_vld;
      pass_a = 1'b0;
    end else begin
      if (a_vld && b_vld && (a_dst[BIT] == b_dst[BIT])) begin
        if (a_src < b_src) begin
          b_lost = 1'b1;
          pass_b = 1'b0;
        end else begin
          a_lost = 1'b1;
          pass_a = 1'b0;
        end
      end
      if (pass_a)      mode = a_dst[BIT] ? SW_CROSS : SW_STRAIGHT;
      else if (pass_b) mode = b_dst[BIT] ? SW_STRAIGHT : SW_CROSS;
    end
  end

  always_comb begin
    unique case (mode)
      SW_CROSS: begin
        u_vld = pass_b; u_bc = b_bc; u_dst = b_dst; u_src = b_src; u_dat = b_dat;
        l_vld = pass_a; l_bc = a_bc; l_dst = a_dst; l_src = a_src; l_dat = a_dat;
      end
      SW_UP_BCAST: begin
        u_vld = pass_a; u_bc = a_bc; u_dst = a_dst; u_src = a_src; u_dat = a_dat;
        l_vld = pass_a; l_bc = a_bc; l_dst = a_dst; l_src = a_src; l_dat = a_dat;
      end
      SW_LO_BCAST: begin
        u_vld = pass_b; u_bc = b_bc; u_dst = b_dst; u_src = b_src; u_dat = b_dat;
        l_vld = pass_b; l_bc = b_bc; l_dst = b_dst; l_src = b_src; l_dat = b_dat;
      end
      default: begin
        u_vld = pass_a; u_bc = a_bc; u_dst = a_dst; u_src = a_src; u_dat = a_dat;
        l_vld = pass_b; l_bc = b_bc; l_dst = b_dst; l_src = b_src; l_dat = b_dat;
      end
    endcase
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int N    = 8,
  parameter int LOGN = 3,
  parameter int W    = 16,
  parameter int STG  = 0
) (
  input  logic [N-1:0]           i_vld,
  input  logic [N-1:0]           i_bc,
  input  logic [N-1:0][LOGN-1:0] i_dst,
  input  logic [N-1:0][LOGN-1:0] i_src,
  input  logic [N-1:0][W-1:0]    i_dat,
  output logic [N-1:0]           o_vld,
  output logic [N-1:0]           o_bc,
  output logic [N-1:0][LOGN-1:0] o_dst,
  output logic [N-1:0][LOGN-1:0] o_src,
  output logic [N-1:0][W-1:0]    o_dat,
  output logic [N-1:0]           blk
);
  localparam int HALF = N / 2;
  localparam int BIT  = LOGN - 1 - STG;

  logic [N-1:0]           s_vld, s_bc;
  logic [N-1:0][LOGN-1:0] s_dst, s_src;
  logic [N-1:0][W-1:0]    s_dat;
  logic [HALF-1:0]        lost_a, lost_b;

  for (genvar q = 0; q < N; q++) begin : g_shuf
    localparam int FROM = shuffle_from(q, LOGN);
    assign s_vld[q] = i_vld[FROM];
    assign s_bc[q]  = i_bc[FROM];
    assign s_dst[q] = i_dst[FROM];
    assign s_src[q] = i_src[FROM];
    assign s_dat[q] = i_dat[FROM];
  end

  for (genvar j = 0; j < HALF; j++) begin : g_sw
    omega_switch #(.LOGN(LOGN), .W(W), .BIT(BIT)) u_sw (
      .a_vld (s_vld[2*j]),   .a_bc (s_bc[2*j]),   .a_dst (s_dst[2*j]),
      .a_src (s_src[2*j]),   .a_dat (s_dat[2*j]),
      .b_vld (s_vld[2*j+1]), .b_bc (s_bc[2*j+1]), .b_dst (s_dst[2*j+1]),
      .b_src (s_src[2*j+1]), .b_dat (s_dat[2*j+1]),
      .u_vld (o_vld[2*j]),   .u_bc (o_bc[2*j]),   .u_dst (o_dst[2*j]),
      .u_src (o_src[2*j]),   .u_dat (o_dat[2*j]),
      .l_vld (o_vld[2*j+1]), .l_bc (o_bc[2*j+1]), .l_dst (o_dst[2*j+1]),
      .l_src (o_src[2*j+1]), .l_dat (o_dat[2*j+1]),
      .a_lost(lost_a[j]),    .b_lost(lost_b[j])
    );
  end

  // losers are reported against their input port, carried as the source tag
  always_comb begin
    blk = '0;
    for (int j = 0; j < HALF; j++) begin
      if (lost_a[j]) blk[s_src[2*j]]   = 1'b1;
      if (lost_b[j]) blk[s_src[2*j+1]] = 1'b1;
    end
  end
endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter  int N    = 8,
  parameter  int W    = 16,
  localparam int LOGN = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N-1:0]           in_valid,
  input  logic [N-1:0]           in_bcast,
  input  logic [N-1:0][LOGN-1:0] in_dest,
  input  logic [N-1:0][W-1:0]    in_data,
  output logic [N-1:0]           out_valid,
  output logic [N-1:0][W-1:0]    out_data,
  output logic [N-1:0][LOGN-1:0] out_src,
  output logic [N-1:0]           blocked
);
  localparam int STAGES = LOGN;

  logic [N-1:0]           ln_vld [0:STAGES];
  logic [N-1:0]           ln_bc  [0:STAGES];
  logic [N-1:0][LOGN-1:0] ln_dst [0:STAGES];
  logic [N-1:0][LOGN-1:0] ln_src [0:STAGES];
  logic [N-1:0][W-1:0]    ln_dat [0:STAGES];
  logic [N-1:0]           blk_acc[0:STAGES];
  logic [N-1:0]           stg_blk[0:STAGES-1];
  logic [N-1:0]           ingress_rej;

  omega_admit #(.N(N)) u_admit (
    .req_vld(in_valid),
    .req_bc (in_bcast),
    .adm_vld(ln_vld[0]),
    .adm_bc (ln_bc[0]),
    .rej    (ingress_rej)
  );

  assign ln_dst[0]  = in_dest;
  assign ln_dat[0]  = in_data;
  assign blk_acc[0] = ingress_rej;

  for (genvar i = 0; i < N; i++) begin : g_tag
    assign ln_src[0][i] = LOGN'(i);
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    omega_stage #(.N(N), .LOGN(LOGN), .W(W), .STG(k)) u_stage (
      .i_vld(ln_vld[k]),   .i_bc(ln_bc[k]),   .i_dst(ln_dst[k]),
      .i_src(ln_src[k]),   .i_dat(ln_dat[k]),
      .o_vld(ln_vld[k+1]), .o_bc(ln_bc[k+1]), .o_dst(ln_dst[k+1]),
      .o_src(ln_src[k+1]), .o_dat(ln_dat[k+1]),
      .blk  (stg_blk[k])
    );
    assign blk_acc[k+1] = blk_acc[k] | stg_blk[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_data  <= '0;
      out_src   <= '0;
      blocked   <= '0;
    end else begin
      out_valid <= ln_vld[STAGES];
      blocked   <= blk_acc[STAGES];
      for (int p = 0; p < N; p++) begin
        out_data[p] <= ln_vld[STAGES][p] ? ln_dat[STAGES][p] : '0;
        out_src[p]  <= ln_vld[STAGES][p] ? ln_src[STAGES][p] : '0;
      end
    end
  end
endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] in_valid,
  input logic [N-1:0] in_bcast,
  input logic [N-1:0] out_valid,
  input logic [N-1:0] blocked
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && blocked == '0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid == '0) |=> (out_valid == '0 && blocked == '0));

  // R7
  conserve_chk: assert property (@(posedge clk) disable iff (rst)
    ((in_valid & in_bcast) == '0) |=>
      ($countones(out_valid) + $countones(blocked) == $countones($past(in_valid))));

  // R7
  blk_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((blocked & ~$past(in_valid)) == '0));

  // R6
  port0_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid[0] && !in_bcast[0]) |=> !blocked[0]);

  // R8
  bcast_all_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(in_valid) == 1 && (in_valid & in_bcast) != '0) |=>
      (out_valid == '1 && blocked == '0));
endmodule

bind omega_fabric omega_fabric_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_bcast(in_bcast),
  .out_valid(out_valid), .blocked(blocked)
);

// File: tb/sim_omega_fabric.sv
`timescale 1ns/1ps
module sim_omega_fabric;
  localparam int N = 8;
  localparam int W = 16;
  localparam int L = 3;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [N-1:0]        in_valid = '0, in_bcast = '0;
  logic [N-1:0][L-1:0] in_dest = '0;
  logic [N-1:0][W-1:0] in_data = '0;
  logic [N-1:0]        out_valid, blocked;
  logic [N-1:0][W-1:0] out_data;
  logic [N-1:0][L-1:0] out_src;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0]        e_vld, e_blk;
  logic [N-1:0][W-1:0] e_dat;
  logic [N-1:0][L-1:0] e_src;

  omega_fabric #(.N(N), .W(W)) u0 (.*);

  always #4 clk = ~clk;  // 125 MHz

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural model: link occupied after stage k is the low bits of {src,dest} shifted
  task automatic model();
    int nv = 0;
    bit alive [N];
    e_vld = '0; e_blk = '0; e_dat = '0; e_src = '0;
    for (int s = 0; s < N; s++) if (in_valid[s]) nv++;
    for (int s = 0; s < N; s++) begin
      alive[s] = in_valid[s] && !in_bcast[s];
      if (in_valid[s] && in_bcast[s]) begin
        if (nv == 1) begin
          for (int p = 0; p < N; p++) begin
            e_vld[p] = 1'b1; e_dat[p] = in_data[s]; e_src[p] = L'(s);
          end
        end else e_blk[s] = 1'b1;
      end
    end
    for (int k = 0; k < L; k++) begin
      int owner [N];
      for (int p = 0; p < N; p++) owner[p] = -1;
      for (int s = 0; s < N; s++) begin
        if (alive[s]) begin
          int pos = ((s << (k + 1)) | (int'(in_dest[s]) >> (L - 1 - k))) & (N - 1);
          if (owner[pos] >= 0) begin
            alive[s] = 0; e_blk[s] = 1'b1;
          end else owner[pos] = s;
        end
      end
    end
    for (int s = 0; s < N; s++)
      if (alive[s]) begin
        e_vld[in_dest[s]] = 1'b1;
        e_dat[in_dest[s]] = in_data[s];
        e_src[in_dest[s]] = L'(s);
      end
  endtask

  task automatic compare(string tag);
    for (int p = 0; p < N; p++) begin
      check(tag, $sformatf("out_valid[%0d]", p), out_valid[p], e_vld[p]);
      check(tag, $sformatf("out_data[%0d]", p), out_data[p], e_dat[p]);
      check(tag, $sformatf("out_src[%0d]", p), out_src[p], e_src[p]);
      check(tag, $sformatf("blocked[%0d]", p), blocked[p], e_blk[p]);
    end
  endtask

  // inputs set at negedge, captured at posedge, compared at the following negedge
  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear();
    in_valid = '0; in_bcast = '0; in_dest = '0;
  endtask

  task automatic put(int s, int d, bit bc = 0);
    in_valid[s] = 1'b1; in_bcast[s] = bc; in_dest[s] = L'(d);
    in_data[s] = W'(16'h1000 + s * 16'h0111 + d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with traffic applied during reset
    @(negedge clk);
    for (int s = 0; s < N; s++) put(s, s);
    @(posedge clk); @(negedge clk);
    e_vld = '0; e_blk = '0; e_dat = '0; e_src = '0;
    compare("R1");
    clear();
    rst = 1'b0;

    // R2: idle cycle
    step("R2");

    // R4: reversal
    for (int s = 0; s < N; s++) put(s, N - 1 - s);
    step("R4");
    check("R4", "blocked", blocked, 0);
    // R2: one cycle only
    clear(); step("R2");

    // R10: identity
    for (int s = 0; s < N; s++) put(s, s);
    step("R10");
    check("R10", "blocked", blocked, 0);
    clear();

    // R5: internal collision, output 4 free but unreachable
    put(0, 5); put(6, 4);
    step("R5");
    check("R5", "blocked[6]", blocked[6], 1);
    check("R5", "out_valid[4]", out_valid[4], 0);
    check("R5", "out_valid[5]", out_valid[5], 1);
    clear();

    // R6: everyone to output 3
    for (int s = 0; s < N; s++) put(s, 3);
    step("R6");
    check("R6", "out_src[3]", out_src[3], 0);
    check("R6", "blocked", blocked, 8'hFE);
    clear();
    put(5, 2); put(2, 2);
    step("R6");
    check("R6", "out_src[2]", out_src[2], 2);
    clear();

    // R3: single requests from every port to every destination
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        clear(); put(s, d); step("R3");
      end
    clear();

    // R8: lone broadcast, dest bits arbitrary
    put(5, 6, 1);
    step("R8");
    check("R8", "out_valid", out_valid, 8'hFF);
    check("R8", "out_src[0]", out_src[0], 5);
    clear();
    put(0, 0, 1); step("R8"); clear();

    // R9: broadcast with company
    put(3, 1, 1); put(6, 2);
    step("R9");
    check("R9", "blocked[3]", blocked[3], 1);
    check("R9", "out_valid[2]", out_valid[2], 1);
    clear();
    put(1, 0, 1); put(4, 0, 1);
    step("R9");
    check("R9", "blocked", blocked, 8'h12);
    clear();

    // R7: random traffic, compared every clock
    for (int n = 0; n < 3000; n++) begin
      clear();
      for (int s = 0; s < N; s++) begin
        if ($urandom_range(0, 3) != 0) begin
          put(s, $urandom_range(0, N - 1), ($urandom_range(0, 15) == 0));
          in_data[s] = W'($urandom);
        end
      end
      if ($urandom_range(0, 19) == 0) begin
        clear(); put($urandom_range(0, N - 1), $urandom_range(0, N - 1), 1);
      end
      step("R7");
    end
    clear();
    step("R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule